// File: doc/BRIEF.md
# Sixteen-bit shift and rotate unit with condition flags

This block is the shift-and-rotate slice of a small 16-bit execution datapath. One request carries an operand, a 3-bit operation code, a shift count and the incoming carry. The unit returns the shifted or rotated word one clock later, with fresh negative (N), zero (Z), overflow (V) and carry (C) flags. The count comes from one of two places, chosen by a select input. It is either a 4-bit field taken from the instruction word or the full 16-bit value of a source register. Fetching the operand and writing the result back are the job of the surrounding pipeline.

The operations are:

- arithmetic right shift;
- logical left and right shift, with zero fill;
- carry-fill left and right shift, where every vacated position takes the incoming carry;
- left and right rotate.

For the shifts, V means "the sign bit changed" and not signed overflow. C always holds the last bit that left the word.

Top module: `shf16_unit`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the next clock edge. While `in_valid` is low, `out_valid` is low and `result` and the flags hold their previous values.
- R2: In immediate mode (`use_reg`=0), the shift amount is `imm_cnt` for 1..15. A field value of 0 means a shift of 16.
- R3: In register mode (`use_reg`=1), shift operations use `reg_cnt` limited to 16 (any value ≥16 shifts by 16). Rotates use only `reg_cnt[3:0]`.
- R4: Operation code 1 (arithmetic right) fills the vacated high bits with the operand's bit 15.
- R5: Code 5 (logical right) and code 4 (logical left) fill the vacated bits with 0. A shift of 16 gives 0.
- R6: Code 3 (carry-fill right) and code 2 (carry-fill left) fill every vacated bit with `carry_in`.
- R7: For shifts with a non-zero amount n, `flag_c` is the last bit shifted out. That is operand bit n-1 for right shifts and bit 16-n for left shifts.
- R8: For codes 2..5, `flag_v` is bit 15 of the result XOR bit 15 of the operand. For codes 0, 1, 6 and 7, `flag_v` is 0.
- R9: Code 6 rotates left and code 7 rotates right, by the amount modulo 16. A rotate leaves `flag_c` equal to `carry_in`.
- R10: `flag_n` equals bit 15 of the result. `flag_z` is 1 exactly when the result is zero.
- R11: A register-mode amount of 0 returns the operand unchanged, with `flag_c` = `carry_in` and `flag_v` = 0.
- R12: Code 0 passes the operand through, with `flag_c` = `carry_in` and `flag_v` = 0.
- R13: While `rst_n` is low, `out_valid`, `result` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (0 pass, 1 ASR, 2 CSL, 3 CSR, 4 LSL, 5 LSR, 6 ROL, 7 ROR) |
| operand | input | 16 | Word to shift |
| imm_cnt | input | 4 | Immediate count field |
| reg_cnt | input | 16 | Register count value |
| use_reg | input | 1 | 1 selects `reg_cnt`, 0 selects `imm_cnt` |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 16 | Shifted or rotated word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Sign-change / overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions assume that every input is a known value in any cycle where `in_valid` is high, and that any of the eight operation codes may arrive. They also rely on the vacated-bit masks, which are derived from the resolved amount and not from the shift network, so the fill checks compare two separately built pieces of logic. The stimulus is driven only on falling edges and always from fully defined values. It sweeps every code against all sixteen immediate fields. It then sweeps register counts 0..20 plus values far above 16, which reach the saturation and modulo-16 paths that the assertions cover.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ASR  = 3'd1,
    OP_CSL  = 3'd2,
    OP_CSR  = 3'd3,
    OP_LSL  = 3'd4,
    OP_LSR  = 3'd5,
    OP_ROL  = 3'd6,
    OP_ROR  = 3'd7
  } shf_op_e;

  function automatic logic op_is_rot(input shf_op_e o);
    return (o == OP_ROL) || (o == OP_ROR);
  endfunction

  function automatic logic op_is_left(input shf_op_e o);
    return (o == OP_CSL) || (o == OP_LSL) || (o == OP_ROL);
  endfunction

  function automatic logic op_tracks_sign(input shf_op_e o);
    return (o == OP_CSL) || (o == OP_CSR) || (o == OP_LSL) || (o == OP_LSR);
  endfunction

endpackage

// File: rtl/shf_count.sv
module shf_count import shf_pkg::*; #(
  parameter int W     = 16,
  parameter int IMM_W = $clog2(W),
  parameter int CW    = $clog2(W) + 1
) (
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [W-1:0]     reg_cnt,
  input  logic             rotate,
  output logic [CW-1:0]    amt,
  output logic             zero_amt,
  output logic [W-1:0]     vac_lo,
  output logic [W-1:0]     vac_hi
);

  localparam logic [CW-1:0] FULL   = CW'(W);
  localparam logic [W-1:0]  FULL_W = W'(W);

  logic reg_sat;
  assign reg_sat = (reg_cnt >= FULL_W);

  always_comb begin
    if (!use_reg) begin
      amt = (imm_cnt == '0) ? FULL : {1'b0, imm_cnt};
    end else if (rotate) begin
      amt = {1'b0, reg_cnt[IMM_W-1:0]};
    end else if (reg_sat) begin
      amt = FULL;
    end else begin
      amt = reg_cnt[CW-1:0];
    end
  end

  assign zero_amt = (amt == '0);

  // Vacated positions: low bits for left moves, high bits for right moves.
  for (genvar i = 0; i < W; i++) begin : g_vac
    assign vac_lo[i] = (int'(amt) > i);
    assign vac_hi[i] = ((int'(amt) + i) >= W);
  end

endmodule

// File: rtl/shf_core.sv
module shf_core import shf_pkg::*; #(
  parameter int W  = 16,
  parameter int CW = $clog2(W) + 1
) (
  input  shf_op_e       op,
  input  logic [W-1:0]  operand,
  input  logic [CW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  shifted,
  output logic          last_out
);

  // Right funnel: {fill, value, guard} moved right; the guard slot catches the last bit out.
  function automatic logic [W:0] go_right(input logic [W-1:0] v, input logic [W-1:0] f,
                                          input logic [CW-1:0] n);
    logic [2*W:0] ext;
    ext = {f, v, 1'b0} >> n;
    return {ext[0], ext[W:1]};
  endfunction

  // Left funnel: {guard, value, fill} moved left; the guard slot catches the last bit out.
  function automatic logic [W:0] go_left(input logic [W-1:0] v, input logic [W-1:0] f,
                                         input logic [CW-1:0] n);
    logic [2*W:0] ext;
    ext = {1'b0, v, f} << n;
    return {ext[2*W], ext[2*W-1:W]};
  endfunction

  logic [W-1:0] fill;
  logic [W:0]   moved;

  always_comb begin
    unique case (op)
      OP_ASR:         fill = {W{operand[W-1]}};
      OP_CSL, OP_CSR: fill = {W{cin}};
      OP_ROL, OP_ROR: fill = operand;
      default:        fill = '0;
    endcase
  end

  always_comb begin
    if (op == OP_PASS) begin
      moved = {1'b0, operand};
    end else if (op_is_left(op)) begin
      moved = go_left(operand, fill, amt);
    end else begin
      moved = go_right(operand, fill, amt);
    end
  end

  assign shifted  = moved[W-1:0];
  assign last_out = moved[W];

endmodule

// File: rtl/shf_flags.sv
module shf_flags import shf_pkg::*; #(
  parameter int W = 16
) (
  input  shf_op_e      op,
  input  logic         op_sign,
  input  logic [W-1:0] shifted,
  input  logic         last_out,
  input  logic         zero_amt,
  input  logic         cin,
  output logic         n_out,
  output logic         z_out,
  output logic         v_out,
  output logic         c_out
);

  logic keep_c;
  assign keep_c = op_is_rot(op) || (op == OP_PASS) || zero_amt;

  assign n_out = shifted[W-1];
  assign z_out = (shifted == '0);
  assign v_out = op_tracks_sign(op) && (shifted[W-1] != op_sign);
  assign c_out = keep_c ? cin : last_out;

endmodule

// File: rtl/shf16_unit.sv
module shf16_unit import shf_pkg::*; #(
  parameter int WIDTH = 16,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int CW    = $clog2(WIDTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] operand,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [WIDTH-1:0] reg_cnt,
  input  logic             use_reg,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);

  shf_op_e          op_e;
  logic [CW-1:0]    amt;
  logic             zero_amt;
  logic [WIDTH-1:0] vac_lo, vac_hi;
  logic [WIDTH-1:0] shifted;
  logic             last_out;
  logic             n_d, z_d, v_d, c_d;

  assign op_e = shf_op_e'(op_sel);

  shf_count #(.W(WIDTH), .IMM_W(IMM_W), .CW(CW)) u_count (
    .use_reg  (use_reg),
    .imm_cnt  (imm_cnt),
    .reg_cnt  (reg_cnt),
    .rotate   (op_is_rot(op_e)),
    .amt      (amt),
    .zero_amt (zero_amt),
    .vac_lo   (vac_lo),
    .vac_hi   (vac_hi)
  );

  shf_core #(.W(WIDTH), .CW(CW)) u_core (
    .op       (op_e),
    .operand  (operand),
    .amt      (amt),
    .cin      (carry_in),
    .shifted  (shifted),
    .last_out (last_out)
  );

  shf_flags #(.W(WIDTH)) u_flags (
    .op       (op_e),
    .op_sign  (operand[WIDTH-1]),
    .shifted  (shifted),
    .last_out (last_out),
    .zero_amt (zero_amt),
    .cin      (carry_in),
    .n_out    (n_d),
    .z_out    (z_d),
    .v_out    (v_d),
    .c_out    (c_d)
  );

  // Captured request, kept as named state for the checks below.
  shf_op_e          op_q;
  logic [WIDTH-1:0] operand_q;
  logic             cin_q;
  logic             zero_q;
  logic [WIDTH-1:0] vac_lo_q, vac_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      op_q      <= OP_PASS;
      operand_q <= '0;
      cin_q     <= 1'b0;
      zero_q    <= 1'b0;
      vac_lo_q  <= '0;
      vac_hi_q  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= shifted;
        flag_n    <= n_d;
        flag_z    <= z_d;
        flag_v    <= v_d;
        flag_c    <= c_d;
        op_q      <= op_e;
        operand_q <= operand;
        cin_q     <= carry_in;
        zero_q    <= zero_amt && use_reg;
        vac_lo_q  <= vac_lo;
        vac_hi_q  <= vac_hi;
      end
    end
  end

  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c)));

  p_asr_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_ASR) |->
      ((result & vac_hi_q) == ({WIDTH{operand_q[WIDTH-1]}} & vac_hi_q)));

  p_lsl_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_LSL) |-> ((result & vac_lo_q) == '0));

  p_lsr_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_LSR) |-> ((result & vac_hi_q) == '0));

  p_csl_carry_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_CSL) |->
      ((result & vac_lo_q) == ({WIDTH{cin_q}} & vac_lo_q)));

  p_csr_carry_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_CSR) |->
      ((result & vac_hi_q) == ({WIDTH{cin_q}} & vac_hi_q)));

  p_v_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_q == OP_ASR || op_q == OP_PASS)) |-> !flag_v);

  p_rot_keeps_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (op_q == OP_ROL || op_q == OP_ROR)) |->
      (($countones(result) == $countones(operand_q)) && flag_c == cin_q && !flag_v));

  p_nz_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (flag_z == (result == '0) && flag_n == result[WIDTH-1]));

  p_zero_amt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zero_q) |-> (result == operand_q && flag_c == cin_q && !flag_v));

  p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_PASS) |-> (result == operand_q && flag_c == cin_q));

endmodule

// File: tb/sim_shf16_unit.sv
`timescale 1ns/1ps
module sim_shf16_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [15:0] operand = '0;
  logic [3:0]  imm_cnt = '0;
  logic [15:0] reg_cnt = '0;
  logic        use_reg = 1'b0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  shf16_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .use_reg(use_reg),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Bit-serial reference: one position per step, tracking the bit that leaves.
  task automatic model(input logic [2:0] o, input logic [3:0] im, input logic [15:0] rc,
                       input logic ur, input logic ci, input logic [15:0] a,
                       output logic [15:0] r, output logic n, output logic z,
                       output logic v, output logic c, output int k);
    if (ur) k = (o >= 3'd6) ? int'(rc % 16) : ((rc > 16) ? 16 : int'(rc));
    else    k = (im == 0) ? 16 : int'(im);
    r = a;
    c = ci;
    if (o != 3'd0) begin
      for (int i = 0; i < k; i++) begin
        case (o)
          3'd1: begin c = r[0];  r = {r[15], r[15:1]}; end
          3'd2: begin c = r[15]; r = {r[14:0], ci};    end
          3'd3: begin c = r[0];  r = {ci, r[15:1]};    end
          3'd4: begin c = r[15]; r = {r[14:0], 1'b0};  end
          3'd5: begin c = r[0];  r = {1'b0, r[15:1]};  end
          3'd6: r = {r[14:0], r[15]};
          default: r = {r[0], r[15:1]};
        endcase
      end
    end
    n = r[15];
    z = (r == 16'h0);
    v = (o >= 3'd2 && o <= 3'd5) ? (r[15] ^ a[15]) : 1'b0;
  endtask

  task automatic run(input logic [2:0] o, input logic [3:0] im, input logic [15:0] rc,
                     input logic ur, input logic ci, input logic [15:0] a);
    logic [15:0] er;
    logic en, ez, ev, ec;
    int k;
    string rt, ct, cnt_tag;
    model(o, im, rc, ur, ci, a, er, en, ez, ev, ec, k);
    cnt_tag = ur ? "R3" : "R2";
    case (o)
      3'd0:       rt = "R12";
      3'd1:       rt = "R4";
      3'd2, 3'd3: rt = "R6";
      3'd4, 3'd5: rt = "R5";
      default:    rt = "R9";
    endcase
    if (ur && k == 0) rt = "R11";
    ct = (o >= 3'd6 || o == 3'd0 || k == 0) ? rt : "R7";
    @(negedge clk);
    op_sel = o; imm_cnt = im; reg_cnt = rc; use_reg = ur; carry_in = ci; operand = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "out_valid after request", {15'd0, out_valid}, 16'd1);
    chk(rt, $sformatf("%s result op=%0d cnt=%0d a=%h", cnt_tag, o, k, a), result, er);
    chk(ct, $sformatf("carry op=%0d cnt=%0d", o, k), {15'd0, flag_c}, {15'd0, ec});
    chk("R8", $sformatf("flag_v op=%0d cnt=%0d", o, k), {15'd0, flag_v}, {15'd0, ev});
    chk("R10", "flag_n/flag_z", {14'd0, flag_n, flag_z}, {14'd0, en, ez});
    // Idle cycle with different inputs: nothing may move.
    operand = ~a; carry_in = ~ci;
    @(negedge clk);
    chk("R1", "out_valid idle", {15'd0, out_valid}, 16'd0);
    chk("R1", "result held while idle", result, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] pats [6];
    logic [15:0] rcs [24];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8001;
    pats[3] = 16'h7FFE; pats[4] = 16'hA5C3; pats[5] = 16'h1234;
    for (int i = 0; i <= 20; i++) rcs[i] = 16'(i);
    rcs[21] = 16'h0100; rcs[22] = 16'hFFFF; rcs[23] = 16'h0031;

    // R13: reset state
    operand = 16'hBEEF; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13", "out_valid in reset", {15'd0, out_valid}, 16'd0);
    chk("R13", "result in reset", result, 16'd0);
    chk("R13", "flags in reset", {12'd0, flag_n, flag_z, flag_v, flag_c}, 16'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Immediate-count sweep (R2)
    for (int o = 0; o < 8; o++)
      for (int im = 0; im < 16; im++)
        for (int p = 0; p < 6; p++)
          for (int ci = 0; ci < 2; ci++)
            run(3'(o), 4'(im), 16'h0, 1'b0, 1'(ci), pats[p]);

    // Register-count sweep: saturation, modulo for rotates, zero amount (R3, R11)
    for (int o = 0; o < 8; o++)
      for (int r = 0; r < 24; r++)
        for (int p = 0; p < 6; p++)
          for (int ci = 0; ci < 2; ci++)
            run(3'(o), 4'h0, rcs[r], 1'b1, 1'(ci), pats[p]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule